// File: doc/BRIEF.md
# Ten-Bit I2C Slave Address Recogniser

This block follows the address phase of an I2C target whose own address is ten bits wide. A bit-level front end, outside this block, turns the two bus wires into single-cycle events: START, repeated START and STOP. It also delivers each received byte with a one-cycle strobe. From those events the block decides whether the ninth-bit acknowledge for each address byte should be driven. It then reports whether the target is selected and whether it acts as a receiver or a transmitter.

A write transfer carries a header byte and then a low address byte. The header byte is the prefix `11110`, then the two upper address bits, then the read/write bit. The block remembers a completed ten-bit match. Because of that, a repeated START followed by a header alone, with the read bit set, turns the target into a transmitter. When the header byte is accepted, a flag pulse tells software that the byte in hand is an address and not payload. A strobe marks the bytes that are payload.

Top module: `tenbit_addr_match`

## Requirements
- R1: A synchronous active-high reset leaves every output low, the remembered match cleared and the bus marked idle.
- R2: After a START, a byte whose bits [7:3] are 11110, whose bits [2:1] equal own-address bits [9:8] and whose bit 0 is 0 produces `ack_o` and `first_byte_o` together, one cycle after the byte strobe.
- R3: After a plain START, a header with bit 0 equal to 1, or a byte whose bits [7:1] do not match, produces no acknowledge. Every following byte up to the next START, repeated START or STOP is then also refused.
- R4: After an accepted header, a second byte equal to own-address bits [7:0] produces `ack_o` one cycle after its strobe. In that same cycle `addressed_o` goes to 1 and `transmit_o` to 0 (receive).
- R5: A second byte that differs from own-address bits [7:0] is not acknowledged and leaves `addressed_o` low. Later bytes produce neither `ack_o` nor `data_strobe_o` until the next START condition.
- R6: While the target is selected as a receiver, each received byte pulses `data_strobe_o` for one cycle and never `ack_o`. No address byte ever pulses `data_strobe_o`.
- R7: After a repeated START, a matching header with bit 0 equal to 1, when a full ten-bit match is remembered, produces `ack_o` and `first_byte_o`. It also sets `addressed_o` and `transmit_o` to 1.
- R8: After a repeated START, a read header is refused and `addressed_o` stays low when no full match is remembered.
- R9: Selection persists across a repeated START. A header that does not select this target then clears `addressed_o` and the remembered match.
- R10: A STOP clears `addressed_o` and the remembered match in the next cycle. A plain START also clears both.
- R11: The own address is captured only while the bus is idle, between a STOP or reset and the next START. Changes made during a transfer have no effect until the bus is idle again.
- R12: `ack_o` is a single-cycle pulse that appears only in the cycle after a byte strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| own_addr_i | input | 10 | Own ten-bit address, static while the bus is busy |
| start_i | input | 1 | START detected (one-cycle pulse) |
| rstart_i | input | 1 | Repeated START detected (one-cycle pulse) |
| stop_i | input | 1 | STOP detected (one-cycle pulse) |
| rx_valid_i | input | 1 | Received byte strobe |
| rx_byte_i | input | 8 | Received byte, MSB first on the wire |
| ack_o | output | 1 | Drive acknowledge in this ninth-bit window |
| first_byte_o | output | 1 | Header byte accepted; the byte is not data |
| data_strobe_o | output | 1 | Received byte is valid payload |
| addressed_o | output | 1 | Target currently selected |
| transmit_o | output | 1 | Direction: 0 receive, 1 transmit |

## Verification
The assertions assume that at most one of the four input events occurs in any cycle. They also assume that two byte strobes are never adjacent, since a real byte takes at least nine bit times. The stimulus drives every event as an isolated one-cycle pulse with idle cycles between. It changes the own address only in cycles without an event. A behavioural model in the bench tracks the expected outputs and is compared against the design every cycle.

// File: rtl/tbam_pkg.sv
package tbam_pkg;

    localparam int BYTE_W   = 8;
    localparam int TAG_W    = 5;
    localparam int HI_W     = 2;
    localparam int LO_W     = 8;
    localparam int ADDR_W   = HI_W + LO_W;
    localparam logic [TAG_W-1:0] HDR_TAG = 5'b11110;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_HDR,
        PH_LOW,
        PH_RECV,
        PH_SEND,
        PH_SKIP
    } phase_e;

    typedef struct packed {
        logic tag_ok;
        logic hi_ok;
        logic rd;
        logic lo_ok;
    } byte_cmp_t;

    typedef struct packed {
        logic ack;
        logic first;
        logic data;
    } pulse_t;

    function automatic logic tag_hit(input logic [BYTE_W-1:0] b);
        return b[BYTE_W-1 -: TAG_W] == HDR_TAG;
    endfunction

    function automatic logic hi_hit(input logic [BYTE_W-1:0] b,
                                    input logic [HI_W-1:0] hi);
        return b[HI_W:1] == hi;
    endfunction

endpackage

// File: rtl/tbam_byte_cmp.sv
module tbam_byte_cmp
    import tbam_pkg::*;
(
    input  logic [BYTE_W-1:0] byte_i,
    input  logic [ADDR_W-1:0] own_i,
    output byte_cmp_t         cmp_o
);
    logic [HI_W-1:0] own_hi;
    logic [LO_W-1:0] own_lo;

    assign own_hi = own_i[ADDR_W-1 -: HI_W];
    assign own_lo = own_i[LO_W-1:0];

    always_comb begin
        cmp_o.tag_ok = tag_hit(byte_i);
        cmp_o.hi_ok  = hi_hit(byte_i, own_hi);
        cmp_o.rd     = byte_i[0];
        cmp_o.lo_ok  = (byte_i == own_lo);
    end
endmodule

// File: rtl/tbam_own_latch.sv
module tbam_own_latch
    import tbam_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              busy_i,
    input  logic [ADDR_W-1:0] own_i,
    output logic [ADDR_W-1:0] own_o
);
    always_ff @(posedge clk) begin
        if (rst || !busy_i)
            own_o <= own_i;
    end

    // R11
    own_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $past(busy_i) |-> $stable(own_o));
endmodule

// File: rtl/tbam_seq.sv
module tbam_seq
    import tbam_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      ev_start,
    input  logic      ev_rstart,
    input  logic      ev_stop,
    input  logic      byte_valid,
    input  byte_cmp_t cmp,
    output logic      ack_o,
    output logic      first_o,
    output logic      data_o,
    output logic      addressed_o,
    output logic      xmit_o,
    output logic      busy_o
);
    phase_e phase_q, phase_d;
    logic   prior_q, prior_d;
    logic   rs_q, rs_d;
    logic   busy_q, busy_d;
    logic   addr_q, addr_d;
    logic   dir_q, dir_d;
    pulse_t pulse_q, pulse_d;
    logic   hdr_match;

    assign hdr_match = cmp.tag_ok && cmp.hi_ok;

    always_comb begin
        phase_d = phase_q;
        prior_d = prior_q;
        rs_d    = rs_q;
        busy_d  = busy_q;
        addr_d  = addr_q;
        dir_d   = dir_q;
        pulse_d = '0;
        if (ev_stop) begin
            phase_d = PH_IDLE;
            prior_d = 1'b0;
            rs_d    = 1'b0;
            busy_d  = 1'b0;
            addr_d  = 1'b0;
            dir_d   = 1'b0;
        end else if (ev_start) begin
            phase_d = PH_HDR;
            prior_d = 1'b0;
            rs_d    = 1'b0;
            busy_d  = 1'b1;
            addr_d  = 1'b0;
            dir_d   = 1'b0;
        end else if (ev_rstart) begin
            phase_d = PH_HDR;
            rs_d    = 1'b1;
            busy_d  = 1'b1;
        end else if (byte_valid) begin
            unique case (phase_q)
                PH_HDR: begin
                    if (hdr_match && !cmp.rd) begin
                        pulse_d.ack   = 1'b1;
                        pulse_d.first = 1'b1;
                        phase_d       = PH_LOW;
                    end else if (hdr_match && rs_q && prior_q) begin
                        pulse_d.ack   = 1'b1;
                        pulse_d.first = 1'b1;
                        phase_d       = PH_SEND;
                        addr_d        = 1'b1;
                        dir_d         = 1'b1;
                    end else begin
                        phase_d = PH_SKIP;
                        prior_d = 1'b0;
                        addr_d  = 1'b0;
                        dir_d   = 1'b0;
                    end
                end
                PH_LOW: begin
                    if (cmp.lo_ok) begin
                        pulse_d.ack = 1'b1;
                        phase_d     = PH_RECV;
                        prior_d     = 1'b1;
                        addr_d      = 1'b1;
                        dir_d       = 1'b0;
                    end else begin
                        phase_d = PH_SKIP;
                        prior_d = 1'b0;
                        addr_d  = 1'b0;
                        dir_d   = 1'b0;
                    end
                end
                PH_RECV: pulse_d.data = 1'b1;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            prior_q <= 1'b0;
            rs_q    <= 1'b0;
            busy_q  <= 1'b0;
            addr_q  <= 1'b0;
            dir_q   <= 1'b0;
            pulse_q <= '0;
        end else begin
            phase_q <= phase_d;
            prior_q <= prior_d;
            rs_q    <= rs_d;
            busy_q  <= busy_d;
            addr_q  <= addr_d;
            dir_q   <= dir_d;
            pulse_q <= pulse_d;
        end
    end

    assign ack_o       = pulse_q.ack;
    assign first_o     = pulse_q.first;
    assign data_o      = pulse_q.data;
    assign addressed_o = addr_q;
    assign xmit_o      = dir_q;
    assign busy_o      = busy_q;

    // R12
    ack_single_chk: assert property (@(posedge clk) disable iff (rst)
        ack_o |=> !ack_o);
    // R12
    ack_cause_chk: assert property (@(posedge clk) disable iff (rst)
        ack_o |-> $past(byte_valid));
    // R2
    first_with_ack_chk: assert property (@(posedge clk) disable iff (rst)
        first_o |-> ack_o);
    // R6
    data_not_ack_chk: assert property (@(posedge clk) disable iff (rst)
        data_o |-> !ack_o);
    // R10
    stop_clear_chk: assert property (@(posedge clk) disable iff (rst)
        ev_stop |=> (!addressed_o && !prior_q));
    // R8
    no_blind_send_chk: assert property (@(posedge clk) disable iff (rst)
        (byte_valid && !ev_start && !ev_rstart && !ev_stop &&
         phase_q == PH_HDR && cmp.rd && !prior_q) |=> (!ack_o && !xmit_o));
    // R7
    send_needs_addr_chk: assert property (@(posedge clk) disable iff (rst)
        xmit_o |-> addressed_o);
endmodule

// File: rtl/tenbit_addr_match.sv
module tenbit_addr_match
    import tbam_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [9:0]  own_addr_i,
    input  logic        start_i,
    input  logic        rstart_i,
    input  logic        stop_i,
    input  logic        rx_valid_i,
    input  logic [7:0]  rx_byte_i,
    output logic        ack_o,
    output logic        first_byte_o,
    output logic        data_strobe_o,
    output logic        addressed_o,
    output logic        transmit_o
);
    logic [ADDR_W-1:0] own_q;
    logic              busy;
    byte_cmp_t         cmp;

    tbam_own_latch u_own (
        .clk    (clk),
        .rst    (rst),
        .busy_i (busy),
        .own_i  (own_addr_i),
        .own_o  (own_q)
    );

    tbam_byte_cmp u_cmp (
        .byte_i (rx_byte_i),
        .own_i  (own_q),
        .cmp_o  (cmp)
    );

    tbam_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .ev_start    (start_i),
        .ev_rstart   (rstart_i),
        .ev_stop     (stop_i),
        .byte_valid  (rx_valid_i),
        .cmp         (cmp),
        .ack_o       (ack_o),
        .first_o     (first_byte_o),
        .data_o      (data_strobe_o),
        .addressed_o (addressed_o),
        .xmit_o      (transmit_o),
        .busy_o      (busy)
    );
endmodule

// File: tb/tenbit_addr_match_test.sv
`timescale 1ns/1ps
module tenbit_addr_match_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [9:0] own = 10'h2A5;
    logic       st = 1'b0, rs = 1'b0, sp = 1'b0, bv = 1'b0;
    logic [7:0] bd = 8'h00;
    logic       ack, first, dstr, addr, tx;

    int tests = 0;
    int fails = 0;
    bit done  = 0;
    string cur_req = "R1";

    always #4 clk = ~clk;

    tenbit_addr_match uut (
        .clk(clk), .rst(rst), .own_addr_i(own),
        .start_i(st), .rstart_i(rs), .stop_i(sp),
        .rx_valid_i(bv), .rx_byte_i(bd),
        .ack_o(ack), .first_byte_o(first), .data_strobe_o(dstr),
        .addressed_o(addr), .transmit_o(tx)
    );

    // Behavioural reference: phase 0 idle,1 header,2 low,3 recv,4 send,5 skip
    int   m_phase = 0;
    bit   m_prior = 0, m_rs = 0, m_busy = 0;
    bit   m_ack = 0, m_first = 0, m_data = 0, m_addr = 0, m_tx = 0;
    logic [9:0] m_own = 10'h0;

    always @(posedge clk) begin
        if (rst) begin
            m_phase = 0; m_prior = 0; m_rs = 0; m_busy = 0;
            m_ack = 0; m_first = 0; m_data = 0; m_addr = 0; m_tx = 0;
            m_own = own;
        end else begin
            bit was_busy;
            bit hmatch;
            was_busy = m_busy;
            m_ack = 0; m_first = 0; m_data = 0;
            hmatch = (bd[7:3] == 5'd30) && (bd[2:1] == m_own[9:8]);
            if (sp) begin
                m_phase = 0; m_prior = 0; m_rs = 0; m_busy = 0; m_addr = 0; m_tx = 0;
            end else if (st) begin
                m_phase = 1; m_prior = 0; m_rs = 0; m_busy = 1; m_addr = 0; m_tx = 0;
            end else if (rs) begin
                m_phase = 1; m_rs = 1; m_busy = 1;
            end else if (bv) begin
                if (m_phase == 1) begin
                    if (hmatch && bd[0] == 0) begin
                        m_ack = 1; m_first = 1; m_phase = 2;
                    end else if (hmatch && m_rs && m_prior) begin
                        m_ack = 1; m_first = 1; m_phase = 4; m_addr = 1; m_tx = 1;
                    end else begin
                        m_phase = 5; m_prior = 0; m_addr = 0; m_tx = 0;
                    end
                end else if (m_phase == 2) begin
                    if (bd == m_own[7:0]) begin
                        m_ack = 1; m_phase = 3; m_prior = 1; m_addr = 1; m_tx = 0;
                    end else begin
                        m_phase = 5; m_prior = 0; m_addr = 0; m_tx = 0;
                    end
                end else if (m_phase == 3) begin
                    m_data = 1;
                end
            end
            if (!was_busy) m_own = own;
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            tests++;
            if ({ack, first, dstr, addr, tx} !== {m_ack, m_first, m_data, m_addr, m_tx}) begin
                fails++;
                $display("FAIL %s model compare: got %b expected %b at %0t", cur_req,
                         {ack, first, dstr, addr, tx},
                         {m_ack, m_first, m_data, m_addr, m_tx}, $time);
            end
        end
    end

    task automatic chk(input string req, input string what, input logic got, input logic exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: got %b expected %b", req, what, got, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    task automatic pulse_ev(input int which);
        @(posedge clk); #1;
        if (which == 0) st = 1'b1;
        else if (which == 1) rs = 1'b1;
        else sp = 1'b1;
        @(posedge clk); #1;
        st = 1'b0; rs = 1'b0; sp = 1'b0;
        @(negedge clk);
    endtask

    // Sends a byte; samples outputs in the cycle after the strobe
    task automatic send(input logic [7:0] b, output logic a, output logic f, output logic d);
        @(posedge clk); #1;
        bv = 1'b1; bd = b;
        @(posedge clk); #1;
        bv = 1'b0;
        @(negedge clk);
        a = ack; f = first; d = dstr;
        @(negedge clk);
        chk("R12", "ack one cycle", ack, 1'b0);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic a, f, d;
        idle(3);
        rst = 1'b0;
        @(negedge clk);
        cur_req = "R1";
        chk("R1", "ack", ack, 1'b0);
        chk("R1", "addressed", addr, 1'b0);
        chk("R1", "transmit", tx, 1'b0);
        chk("R1", "first", first, 1'b0);

        // write transfer, full match
        cur_req = "R2";
        pulse_ev(0);
        send(8'hF4, a, f, d);
        chk("R2", "header ack", a, 1'b1);
        chk("R2", "first flag", f, 1'b1);
        chk("R6", "no data on header", d, 1'b0);
        cur_req = "R4";
        send(8'hA5, a, f, d);
        chk("R4", "low ack", a, 1'b1);
        chk("R4", "addressed", addr, 1'b1);
        chk("R4", "receive dir", tx, 1'b0);
        chk("R6", "no data on low byte", d, 1'b0);
        cur_req = "R6";
        send(8'h3C, a, f, d);
        chk("R6", "data strobe", d, 1'b1);
        chk("R6", "no ack on data", a, 1'b0);
        cur_req = "R10";
        pulse_ev(2);
        chk("R10", "stop clears", addr, 1'b0);

        // read header after plain start
        cur_req = "R3";
        pulse_ev(0);
        send(8'hF5, a, f, d);
        chk("R3", "read after start refused", a, 1'b0);
        pulse_ev(2);
        pulse_ev(0);
        send(8'hF0, a, f, d);
        chk("R3", "wrong upper bits", a, 1'b0);
        send(8'hA5, a, f, d);
        chk("R3", "later byte refused", a, 1'b0);
        pulse_ev(2);

        // low byte mismatch
        cur_req = "R5";
        pulse_ev(0);
        send(8'hF4, a, f, d);
        chk("R5", "header ok", a, 1'b1);
        send(8'h5A, a, f, d);
        chk("R5", "low mismatch ack", a, 1'b0);
        chk("R5", "not addressed", addr, 1'b0);
        send(8'hA5, a, f, d);
        chk("R5", "no late ack", a, 1'b0);
        chk("R5", "no data", d, 1'b0);
        cur_req = "R8";
        pulse_ev(1);
        send(8'hF5, a, f, d);
        chk("R8", "read without prior", a, 1'b0);
        chk("R8", "not addressed", addr, 1'b0);
        pulse_ev(2);

        // turnaround to transmitter
        cur_req = "R7";
        pulse_ev(0);
        send(8'hF4, a, f, d);
        send(8'hA5, a, f, d);
        pulse_ev(1);
        chk("R9", "kept across rstart", addr, 1'b1);
        send(8'hF5, a, f, d);
        chk("R7", "read ack", a, 1'b1);
        chk("R7", "first flag", f, 1'b1);
        chk("R7", "addressed", addr, 1'b1);
        chk("R7", "transmit dir", tx, 1'b1);
        pulse_ev(2);
        chk("R10", "stop clears tx", tx, 1'b0);

        // other target after rstart
        cur_req = "R9";
        pulse_ev(0);
        send(8'hF4, a, f, d);
        send(8'hA5, a, f, d);
        pulse_ev(1);
        send(8'hF6, a, f, d);
        chk("R9", "other header refused", a, 1'b0);
        chk("R9", "deselected", addr, 1'b0);
        pulse_ev(1);
        send(8'hF5, a, f, d);
        chk("R9", "prior forgotten", a, 1'b0);
        pulse_ev(2);

        // plain start drops prior
        cur_req = "R10";
        pulse_ev(0);
        send(8'hF4, a, f, d);
        send(8'hA5, a, f, d);
        pulse_ev(0);
        chk("R10", "start clears addressed", addr, 1'b0);
        pulse_ev(1);
        send(8'hF5, a, f, d);
        chk("R10", "prior cleared by start", a, 1'b0);
        pulse_ev(2);

        // own address change mid transfer
        cur_req = "R11";
        pulse_ev(0);
        own = 10'h0FF;
        idle(2);
        send(8'hF4, a, f, d);
        chk("R11", "old header still used", a, 1'b1);
        send(8'hA5, a, f, d);
        chk("R11", "old low still used", a, 1'b1);
        pulse_ev(2);
        idle(3);
        pulse_ev(0);
        send(8'hF0, a, f, d);
        chk("R11", "new header", a, 1'b1);
        send(8'hFF, a, f, d);
        chk("R11", "new low", a, 1'b1);
        pulse_ev(2);

        idle(3);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule